// File: doc/BRIEF.md
# Coprocessor Bus Address Decoder

This block sits on the address bus of a coprocessor-side CPU and turns each 24-bit bus access into exactly one region select: register I/O, program ROM, internal RAM, linear work RAM or a packed-pixel bitmap view. For each access it also produces the address local to that region. Banks with bit 23 set mirror banks with bit 23 clear in the system-bus half of the map. An 8 KB window in that half is steered by a block-number input and a mode bit, either into linear work RAM or into the bitmap view.

An access starts when a read or write strobe is seen while the decoder is idle. The select, the local address and the write data are captured at that edge and held until the access ends. A ready pulse marks the last clock of the access. Plain accesses take 2 clocks. Work-RAM-class accesses take 4 clocks.

A read that hits no region completes with an open-bus flag and returns the bus data byte captured at acceptance. A write to ROM or to unmapped space completes without a select and without a write strobe.

Top module: `cop_bus_decoder`

## Requirements
- R1: Banks 00-3F and 80-BF at offsets 2200-23FF select register I/O (sel_o bit 0), with local address = addr[8:0]. This match is taken before any other.
- R2: Reads of banks 00-3F and 80-BF at offsets 8000-FFFF select ROM (sel_o bit 1), with local address = {2'b0, addr[23], addr[21:16], addr[14:0]}.
- R3: Reads of banks C0-FF select ROM with the address unchanged. A write to any ROM address completes with sel_o = 0 and wr_o never asserted.
- R4: Offsets 0000-07FF and 3000-37FF in banks 00-3F and 80-BF select internal RAM (sel_o bit 2), with local address = addr[10:0].
- R5: Banks 40-4F select work RAM (sel_o bit 3), with local address = addr masked to the RAM size (18 bits by default). Banks 60-6F select the bitmap view (sel_o bit 4), with local address = addr[19:0].
- R6: With win_bitmap_i = 0, offsets 6000-7FFF in banks 00-3F and 80-BF select work RAM at (win_block_i[4:0] * 0x2000 + addr[12:0]), masked to the RAM size.
- R7: With win_bitmap_i = 1, the same window selects the bitmap view at (win_block_i * 0x2000 + addr[12:0]) masked to 20 bits.
- R8: A read that hits no region completes with sel_o = 0, open_bus_o high for the ready cycle, and rdata_o equal to last_data_i as sampled at acceptance. An unmapped write completes with no select and no wr_o. A mapped writable write raises wr_o with wdata_o only in the ready cycle.
- R9: Counted from the accepting clock edge, ready_o rises after 2 clocks for plain accesses. It rises after 4 clocks for the 6000-7FFF window and for addresses with (addr & 0xD00000) == 0x400000. ready_o is high for exactly one clock.
- R10: sel_o has at most one bit set. sel_o and local_addr_o stay stable from acceptance until ready.
- R11: Strobes seen while an access is in progress are ignored and start nothing. When rd_i and wr_i are both high, the access is a read.
- R12: After reset, ready_o, wr_o, open_bus_o and sel_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 24 | Bus address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| last_data_i | input | 8 | Last byte seen on the data bus (open-bus value) |
| win_block_i | input | 8 | Block number of the 6000-7FFF window |
| win_bitmap_i | input | 1 | Window mode: 0 work RAM, 1 bitmap view |
| sel_o | output | 5 | One-hot region select {bitmap, wram, iram, rom, io} |
| local_addr_o | output | 24 | Region-local address |
| wr_o | output | 1 | Write strobe to the selected region |
| wdata_o | output | 8 | Captured write data |
| open_bus_o | output | 1 | Unmapped read completes this cycle |
| rdata_o | output | 8 | Open-bus data for an unmapped read |
| ready_o | output | 1 | Access completes this cycle |

## Verification
Two things can happen in the same cycle. A new strobe can arrive while an access is still counting wait states, and a read and a write strobe can be raised together. The bench provokes the first by pulsing a ROM read one cycle after a slow work-RAM read has been accepted. It then checks that the slow access completes with its own select and local address after 4 clocks, and that no second ready follows. For the second, both strobes are raised on a ROM address. The access must decode as a ROM read and wr_o must stay low.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  typedef enum logic [2:0] {
    RK_MISS, RK_IO, RK_ROM_LO, RK_ROM_HI, RK_WIN, RK_IRAM, RK_WRAM, RK_BMP
  } rule_e;

  typedef enum logic [2:0] {
    RG_NONE, RG_IO, RG_ROM, RG_IRAM, RG_WRAM, RG_BMP
  } region_e;

  localparam int SEL_W    = 5;
  localparam int SEL_IO   = 0;
  localparam int SEL_ROM  = 1;
  localparam int SEL_IRAM = 2;
  localparam int SEL_WRAM = 3;
  localparam int SEL_BMP  = 4;

  function automatic logic [SEL_W-1:0] region_sel(input region_e r);
    logic [SEL_W-1:0] s;
    s = '0;
    case (r)
      RG_IO:   s[SEL_IO]   = 1'b1;
      RG_ROM:  s[SEL_ROM]  = 1'b1;
      RG_IRAM: s[SEL_IRAM] = 1'b1;
      RG_WRAM: s[SEL_WRAM] = 1'b1;
      RG_BMP:  s[SEL_BMP]  = 1'b1;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/cbd_region_match.sv
module cbd_region_match
  import cbd_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [AW-1:0] addr_i,
  input  logic          is_wr_i,
  output rule_e         rule_o,
  output logic          slow_o
);
  localparam int NR = 8;
  // order is priority: index 0 wins
  localparam logic [AW-1:0] MASK [NR] = '{
    24'h40FE00, 24'h408000, 24'hC00000, 24'h40E000,
    24'h40F800, 24'h40F800, 24'hF00000, 24'hF00000};
  localparam logic [AW-1:0] VAL [NR] = '{
    24'h002200, 24'h008000, 24'hC00000, 24'h006000,
    24'h000000, 24'h003000, 24'h400000, 24'h600000};
  localparam rule_e KIND [NR] = '{
    RK_IO, RK_ROM_LO, RK_ROM_HI, RK_WIN,
    RK_IRAM, RK_IRAM, RK_WRAM, RK_BMP};
  localparam logic [NR-1:0] READ_ONLY = 8'b0000_0110;

  logic [NR-1:0] hit;

  for (genvar i = 0; i < NR; i++) begin : g_rule
    assign hit[i] = ((addr_i & MASK[i]) == VAL[i]) && !(is_wr_i && READ_ONLY[i]);
  end

  always_comb begin
    rule_o = RK_MISS;
    for (int i = NR - 1; i >= 0; i--) begin
      if (hit[i]) rule_o = KIND[i];
    end
  end

  assign slow_o = ((addr_i & 24'h40E000) == 24'h006000) ||
                  ((addr_i & 24'hD00000) == 24'h400000);
endmodule

// File: rtl/cbd_translate.sv
module cbd_translate
  import cbd_pkg::*;
#(
  parameter int AW      = 24,
  parameter int IO_AW   = 9,
  parameter int IRAM_AW = 11,
  parameter int WRAM_AW = 18,
  parameter int BMP_AW  = 20,
  parameter int WIN_AW  = 13,
  parameter int BLK_W   = 8
) (
  input  logic [AW-1:0]    addr_i,
  input  rule_e            rule_i,
  input  logic [BLK_W-1:0] block_i,
  input  logic             bitmap_i,
  output region_e          region_o,
  output logic [AW-1:0]    local_o
);
  localparam logic [AW-1:0] IO_MASK   = AW'((1 << IO_AW) - 1);
  localparam logic [AW-1:0] IRAM_MASK = AW'((1 << IRAM_AW) - 1);
  localparam logic [AW-1:0] WRAM_MASK = AW'((1 << WRAM_AW) - 1);
  localparam logic [AW-1:0] BMP_MASK  = AW'((1 << BMP_AW) - 1);
  localparam int WB = 5;  // block bits used by the linear window

  logic [AW-1:0] win_lin, win_bmp, rom_fold;

  assign rom_fold = {2'b00, addr_i[23], addr_i[21:16], addr_i[14:0]};
  assign win_lin  = AW'({block_i[WB-1:0], addr_i[WIN_AW-1:0]}) & WRAM_MASK;
  assign win_bmp  = AW'({block_i, addr_i[WIN_AW-1:0]}) & BMP_MASK;

  always_comb begin
    region_o = RG_NONE;
    local_o  = '0;
    case (rule_i)
      RK_IO:     begin region_o = RG_IO;   local_o = addr_i & IO_MASK;   end
      RK_ROM_LO: begin region_o = RG_ROM;  local_o = rom_fold;           end
      RK_ROM_HI: begin region_o = RG_ROM;  local_o = addr_i;             end
      RK_IRAM:   begin region_o = RG_IRAM; local_o = addr_i & IRAM_MASK; end
      RK_WRAM:   begin region_o = RG_WRAM; local_o = addr_i & WRAM_MASK; end
      RK_BMP:    begin region_o = RG_BMP;  local_o = addr_i & BMP_MASK;  end
      RK_WIN: begin
        if (bitmap_i) begin region_o = RG_BMP;  local_o = win_bmp; end
        else          begin region_o = RG_WRAM; local_o = win_lin; end
      end
      default: begin region_o = RG_NONE; local_o = '0; end
    endcase
  end
endmodule

// File: rtl/cbd_wait_timer.sv
module cbd_wait_timer #(
  parameter int BASE_WAIT = 2,
  parameter int SLOW_WAIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic slow_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(SLOW_WAIT + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= slow_i ? CW'(SLOW_WAIT - 1) : CW'(BASE_WAIT - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/cop_bus_decoder.sv
module cop_bus_decoder
  import cbd_pkg::*;
#(
  parameter int AW        = 24,
  parameter int DW        = 8,
  parameter int BLK_W     = 8,
  parameter int WRAM_AW   = 18,
  parameter int BASE_WAIT = 2,
  parameter int SLOW_WAIT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    last_data_i,
  input  logic [BLK_W-1:0] win_block_i,
  input  logic             win_bitmap_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [AW-1:0]    local_addr_o,
  output logic             wr_o,
  output logic [DW-1:0]    wdata_o,
  output logic             open_bus_o,
  output logic [DW-1:0]    rdata_o,
  output logic             ready_o
);
  logic    is_wr, slow, busy, done, accept;
  rule_e   rule;
  region_e region;
  logic [AW-1:0] local_d;

  logic [SEL_W-1:0] sel_q;
  logic [AW-1:0]    local_q;
  logic [DW-1:0]    wdata_q, obus_q;
  logic             is_wr_q;

  // read wins when both strobes are high
  assign is_wr  = wr_i && !rd_i;
  assign accept = (rd_i || wr_i) && !busy;

  cbd_region_match #(.AW(AW)) u_match (
    .addr_i (addr_i),
    .is_wr_i(is_wr),
    .rule_o (rule),
    .slow_o (slow)
  );

  cbd_translate #(.AW(AW), .WRAM_AW(WRAM_AW), .BLK_W(BLK_W)) u_xlat (
    .addr_i  (addr_i),
    .rule_i  (rule),
    .block_i (win_block_i),
    .bitmap_i(win_bitmap_i),
    .region_o(region),
    .local_o (local_d)
  );

  cbd_wait_timer #(.BASE_WAIT(BASE_WAIT), .SLOW_WAIT(SLOW_WAIT)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .slow_i (slow),
    .busy_o (busy),
    .done_o (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      local_q <= '0;
      wdata_q <= '0;
      obus_q  <= '0;
      is_wr_q <= 1'b0;
    end else if (accept) begin
      sel_q   <= region_sel(region);
      local_q <= local_d;
      wdata_q <= wdata_i;
      obus_q  <= last_data_i;
      is_wr_q <= is_wr;
    end
  end

  assign sel_o        = sel_q;
  assign local_addr_o = local_q;
  assign wdata_o      = wdata_q;
  assign rdata_o      = obus_q;
  assign ready_o      = done;
  assign wr_o         = done && is_wr_q && (sel_q != '0);
  assign open_bus_o   = done && !is_wr_q && (sel_q == '0);
endmodule

// File: rtl/cbd_checker.sv
module cbd_checker
  import cbd_pkg::*;
#(
  parameter int AW = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEL_W-1:0] sel_o,
  input logic [AW-1:0]    local_addr_o,
  input logic             ready_o,
  input logic             wr_o,
  input logic             open_bus_o,
  input logic             busy_i
);
  p_onehot_sel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  p_hold_during_access_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !ready_o) |=> ($stable(sel_o) && $stable(local_addr_o)));

  p_ready_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  p_min_wait_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !ready_o);

  p_write_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (ready_o && sel_o != '0));

  p_rom_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> !sel_o[SEL_ROM]);

  p_open_bus_unmapped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_bus_o |-> (ready_o && sel_o == '0 && !wr_o));
endmodule

bind cop_bus_decoder cbd_checker #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_o       (sel_o),
  .local_addr_o(local_addr_o),
  .ready_o     (ready_o),
  .wr_o        (wr_o),
  .open_bus_o  (open_bus_o),
  .busy_i      (busy)
);

// File: tb/cop_bus_decoder_test.sv
module cop_bus_decoder_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] addr_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0]  wdata_i = '0, last_data_i = '0, win_block_i = '0;
  logic        win_bitmap_i = 1'b0;
  logic [4:0]  sel_o;
  logic [23:0] local_addr_o;
  logic        wr_o, open_bus_o, ready_o;
  logic [7:0]  wdata_o, rdata_o;

  int n_chk = 0, n_fail = 0;

  localparam logic [4:0] S_IO = 5'b00001, S_ROM = 5'b00010, S_IRAM = 5'b00100,
                         S_WRAM = 5'b01000, S_BMP = 5'b10000, S_NONE = 5'b00000;

  always #2.5 clk_i = ~clk_i;

  cop_bus_decoder uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .last_data_i(last_data_i), .win_block_i(win_block_i),
    .win_bitmap_i(win_bitmap_i), .sel_o(sel_o), .local_addr_o(local_addr_o),
    .wr_o(wr_o), .wdata_o(wdata_o), .open_bus_o(open_bus_o), .rdata_o(rdata_o),
    .ready_o(ready_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_acc(input string req, input logic rd, input logic wr,
                         input logic [23:0] a, input logic [7:0] wd, input logic [7:0] bus,
                         input logic [4:0] esel, input logic [23:0] eloc, input int ecyc,
                         input logic ewr, input logic eopen);
    int n;
    logic [4:0] s0;
    logic [23:0] l0;
    logic early_wr, moved;
    @(negedge clk_i);
    addr_i = a; rd_i = rd; wr_i = wr; wdata_i = wd; last_data_i = bus;
    @(negedge clk_i);
    rd_i = 0; wr_i = 0; addr_i = 24'h0; last_data_i = ~bus; wdata_i = ~wd;
    n = 1; s0 = sel_o; l0 = local_addr_o; early_wr = 0; moved = 0;
    while (!ready_o && n < 20) begin
      if (wr_o || open_bus_o) early_wr = 1;
      @(negedge clk_i);
      n++;
      if (sel_o !== s0 || local_addr_o !== l0) moved = 1;
    end
    check("R9", "ready cycles", n, ecyc);
    check(req, "sel", {27'b0, sel_o}, {27'b0, esel});
    check(req, "local addr", {8'b0, local_addr_o}, {8'b0, eloc});
    check("R8", "wr_o at ready", {31'b0, wr_o}, {31'b0, ewr});
    if (ewr) check("R8", "wdata", {24'b0, wdata_o}, {24'b0, wd});
    check("R8", "open bus", {31'b0, open_bus_o}, {31'b0, eopen});
    if (eopen) check("R8", "open bus data", {24'b0, rdata_o}, {24'b0, bus});
    check("R10", "held during access", {31'b0, moved}, 32'b0);
    check("R8", "strobe before ready", {31'b0, early_wr}, 32'b0);
    @(negedge clk_i);
    check("R9", "ready single pulse", {31'b0, ready_o}, 32'b0);
  endtask

  task automatic t_reset();
    check("R12", "ready after reset", {31'b0, ready_o}, 32'b0);
    check("R12", "sel after reset", {27'b0, sel_o}, 32'b0);
    check("R12", "wr after reset", {31'b0, wr_o}, 32'b0);
    check("R12", "open after reset", {31'b0, open_bus_o}, 32'b0);
  endtask

  task automatic t_io();
    run_acc("R1", 1, 0, 24'h9023A7, 8'h00, 8'h11, S_IO, 24'h0001A7, 2, 0, 0);
    run_acc("R1", 0, 1, 24'h002200, 8'hC3, 8'h11, S_IO, 24'h000000, 2, 1, 0);
    // bank 40 is outside the I/O banks
    run_acc("R1", 1, 0, 24'h402200, 8'h00, 8'h11, S_WRAM, 24'h002200, 4, 0, 0);
  endtask

  task automatic t_rom();
    run_acc("R2", 1, 0, 24'hBF8123, 8'h00, 8'h22, S_ROM, 24'h3F8123, 2, 0, 0);
    run_acc("R2", 1, 0, 24'h3A9000, 8'h00, 8'h22, S_ROM, 24'h1D1000, 2, 0, 0);
    run_acc("R2", 1, 0, 24'h00FFEA, 8'h00, 8'h22, S_ROM, 24'h007FEA, 2, 0, 0);
    run_acc("R3", 1, 0, 24'hC12345, 8'h00, 8'h22, S_ROM, 24'hC12345, 2, 0, 0);
    run_acc("R3", 0, 1, 24'hC00010, 8'h77, 8'h22, S_NONE, 24'h000000, 2, 0, 0);
    run_acc("R3", 0, 1, 24'h808000, 8'h77, 8'h22, S_NONE, 24'h000000, 2, 0, 0);
  endtask

  task automatic t_iram();
    run_acc("R4", 1, 0, 24'h0007FF, 8'h00, 8'h33, S_IRAM, 24'h0007FF, 2, 0, 0);
    run_acc("R4", 1, 0, 24'h8034A5, 8'h00, 8'h33, S_IRAM, 24'h0004A5, 2, 0, 0);
    run_acc("R4", 0, 1, 24'h000123, 8'h5C, 8'h33, S_IRAM, 24'h000123, 2, 1, 0);
  endtask

  task automatic t_linear();
    run_acc("R5", 1, 0, 24'h4ABCDE, 8'h00, 8'h44, S_WRAM, 24'h02BCDE, 4, 0, 0);
    run_acc("R5", 0, 1, 24'h6F1234, 8'h0E, 8'h44, S_BMP, 24'h0F1234, 4, 1, 0);
  endtask

  task automatic t_window();
    win_block_i = 8'h25; win_bitmap_i = 0;
    run_acc("R6", 1, 0, 24'h007ABC, 8'h00, 8'h55, S_WRAM, 24'h00BABC, 4, 0, 0);
    run_acc("R6", 0, 1, 24'h816000, 8'hA5, 8'h55, S_WRAM, 24'h00A000, 4, 1, 0);
    win_block_i = 8'hFF; win_bitmap_i = 1;
    run_acc("R7", 1, 0, 24'h007ABC, 8'h00, 8'h55, S_BMP, 24'h0FFABC, 4, 0, 0);
    win_block_i = 8'h03;
    run_acc("R7", 0, 1, 24'hA06001, 8'h02, 8'h55, S_BMP, 24'h006001, 4, 1, 0);
    win_block_i = 8'h00; win_bitmap_i = 0;
  endtask

  task automatic t_unmapped();
    run_acc("R8", 1, 0, 24'h001000, 8'h00, 8'h5A, S_NONE, 24'h000000, 2, 0, 1);
    run_acc("R8", 1, 0, 24'h501234, 8'h00, 8'hE7, S_NONE, 24'h000000, 2, 0, 1);
    run_acc("R8", 0, 1, 24'h501234, 8'h99, 8'hE7, S_NONE, 24'h000000, 2, 0, 0);
  endtask

  task automatic t_both_strobes();
    // R11: read wins
    run_acc("R11", 1, 1, 24'hC00000, 8'h66, 8'h01, S_ROM, 24'hC00000, 2, 0, 0);
  endtask

  task automatic t_busy_ignore();
    int n;
    int extra;
    @(negedge clk_i);
    addr_i = 24'h400010; rd_i = 1;
    @(negedge clk_i);
    addr_i = 24'hC00000; rd_i = 1;  // arrives while busy
    @(negedge clk_i);
    rd_i = 0; addr_i = 24'h0;
    n = 2;
    while (!ready_o && n < 20) begin
      @(negedge clk_i);
      n++;
    end
    check("R11", "busy ready cycles", n, 4);
    check("R11", "busy sel kept", {27'b0, sel_o}, {27'b0, S_WRAM});
    check("R11", "busy local kept", {8'b0, local_addr_o}, 32'h10);
    extra = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (ready_o) extra++;
    end
    check("R11", "no late access", extra, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_io();
    t_rom();
    t_iram();
    t_linear();
    t_window();
    t_unmapped();
    t_both_strobes();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule